// File: doc/BRIEF.md
# Dual-Issue Integer/FP Pairing Logic

This block is the issue stage of a statically scheduled two-way superscalar core. Every cycle the fetch side presents one 64-bit packet carrying two 32-bit instructions. The lower half, the left slot, is reserved for the integer-side instruction: integer ALU operations, integer loads and stores, and FP loads and stores. The upper half, the right slot, is reserved for a floating-point arithmetic operation. The block inspects the class and the six register specifiers of the pair. It then decides whether none, one or both instructions leave this cycle.

Three kinds of conflict are checked. The first is an instruction sitting in the wrong half of the packet; it is treated as a no-op. The second is a dependence inside the pair, where the FP operation reads the register that the FP load beside it writes. The third is a read of a register that a load issued in the previous cycle is still filling, since loads have one cycle of latency. The right slot never overtakes the left. When part of the packet cannot leave, `hold` asks the fetch side to present the same packet again. The block remembers that the left half already left, so it is not issued twice.

Top module: `dual_issue_pair`

## Requirements
- R1: Instruction fields are fixed. In each 32-bit instruction, bits [31:28] are the class, [27:23] the destination, [22:18] source A and [17:13] source B. The left instruction is packet bits [31:0] and the right one is bits [63:32]. Class codes: 0 no-op, 1 integer ALU (int dest, int A, int B), 2 integer load (int dest, int A), 3 integer store (int A base, int B data), 4 FP load (FP dest, int A), 5 FP store (int A base, FP B data), 8 FP operation (FP dest, FP A, FP B).
- R2: A slot that holds a class not allowed in its position never issues and never causes `hold`. Classes 1 to 5 are allowed on the left and class 8 on the right. Class 0 and unused codes are also treated as no-ops.
- R3: When both slots hold legal, independent instructions and nothing is pending, both issue in the same cycle and `hold` stays low. This includes an FP load paired with an FP operation.
- R4: If the left instruction stalls, neither slot issues and `hold` is high. The right slot issues only in a cycle where the left instruction issues, or where the left slot was already issued earlier or is a no-op.
- R5: If the left FP load writes an FP register that the right FP operation reads through source A or B, only the left slot issues and `hold` is high. On the re-presented packet the left instruction is not issued again.
- R6: An instruction that reads, in the same register file, the destination of a load issued in the previous cycle does not issue in that cycle. Integer loads affect the integer sources of the left slot. FP loads affect the FP operation's sources and the FP store's data source.
- R7: Integer and FP register numbers are separate name spaces. Equal numbers in different files never create a hazard.
- R8: While `pkt_valid` is low, nothing issues and `hold` is low.
- R9: While `rst_n` is low, nothing issues and `hold` is low. No load is pending after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pkt_valid | input | 1 | Packet on `pkt` is valid this cycle |
| pkt | input | 64 | Fetch packet: left slot [31:0], right slot [63:32] |
| iss_left | output | 1 | Left instruction issues this cycle |
| iss_right | output | 1 | Right instruction issues this cycle |
| hold | output | 1 | Part of the packet remains; present it again next cycle |

## Verification
The hardest situation to reach is an FP operation that first waits for its paired FP load and is then held a second time on retry. On the retry the load issued one cycle earlier is still outstanding, so the FP operation cannot leave yet. The stimulus presents such a pair and keeps re-presenting the same packet while `hold` is high. This walks through left-only, then nothing, then right-only, for source A and for source B. Separate sequences put a load in one cycle and a consumer in the next, in the same register file and in the other one.

// File: rtl/dual_issue_pair.sv
module dual_issue_pair #(
  parameter int IW = 32,
  parameter int RW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pkt_valid,
  input  logic [2*IW-1:0] pkt,
  output logic          iss_left,
  output logic          iss_right,
  output logic          hold
);
  localparam int CW    = 4;
  localparam int RD_HI = IW - CW - 1;
  localparam int RA_HI = RD_HI - RW;
  localparam int RB_HI = RA_HI - RW;
  localparam int LOW_W = RB_HI - RW + 1;

  localparam logic [CW-1:0] C_IALU = 4'd1;
  localparam logic [CW-1:0] C_ILD  = 4'd2;
  localparam logic [CW-1:0] C_IST  = 4'd3;
  localparam logic [CW-1:0] C_FLD  = 4'd4;
  localparam logic [CW-1:0] C_FST  = 4'd5;
  localparam logic [CW-1:0] C_FOP  = 4'd8;

  logic [IW-1:0] l_ins, r_ins;
  assign l_ins = pkt[IW-1:0];
  assign r_ins = pkt[2*IW-1:IW];

  logic [CW-1:0] l_cls, r_cls;
  logic [RW-1:0] l_rd, l_ra, l_rb, r_ra, r_rb;
  assign l_cls = l_ins[IW-1 -: CW];
  assign l_rd  = l_ins[RD_HI -: RW];
  assign l_ra  = l_ins[RA_HI -: RW];
  assign l_rb  = l_ins[RB_HI -: RW];
  assign r_cls = r_ins[IW-1 -: CW];
  assign r_ra  = r_ins[RA_HI -: RW];
  assign r_rb  = r_ins[RB_HI -: RW];

  logic [LOW_W-1:0] unused_low;
  logic [RW-1:0]    unused_rrd;
  assign unused_low = l_ins[LOW_W-1:0] ^ r_ins[LOW_W-1:0];
  assign unused_rrd = r_ins[RD_HI -: RW];

  // left-slot decode
  logic l_legal, l_ra_int, l_rb_int, l_rb_fp, l_load;
  assign l_legal  = (l_cls == C_IALU) || (l_cls == C_ILD) || (l_cls == C_IST) ||
                    (l_cls == C_FLD)  || (l_cls == C_FST);
  assign l_ra_int = l_legal;
  assign l_rb_int = (l_cls == C_IALU) || (l_cls == C_IST);
  assign l_rb_fp  = (l_cls == C_FST);
  assign l_load   = (l_cls == C_ILD) || (l_cls == C_FLD);

  // one-cycle load tracker and packet remainder state
  logic          pend_v, pend_fp, left_done;
  logic [RW-1:0] pend_rd;

  logic pend_int_hit, pend_fp_left_hit, pend_fp_right_hit;
  assign pend_int_hit      = pend_v && !pend_fp &&
                             ((l_ra_int && l_ra == pend_rd) || (l_rb_int && l_rb == pend_rd));
  assign pend_fp_left_hit  = pend_v && pend_fp && l_rb_fp && (l_rb == pend_rd);
  assign pend_fp_right_hit = pend_v && pend_fp && (r_ra == pend_rd || r_rb == pend_rd);

  logic l_real, l_go, r_real, r_pair_hit;
  assign l_real = rst_n && pkt_valid && !left_done && l_legal;
  assign iss_left = l_real && !(pend_int_hit || pend_fp_left_hit);
  assign l_go   = rst_n && pkt_valid && (left_done || !l_legal || iss_left);

  assign r_real     = rst_n && pkt_valid && (r_cls == C_FOP);
  assign r_pair_hit = iss_left && (l_cls == C_FLD) && (r_ra == l_rd || r_rb == l_rd);
  assign iss_right  = l_go && r_real && !r_pair_hit && !pend_fp_right_hit;

  assign hold = rst_n && pkt_valid && (!l_go || (r_real && !iss_right));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_v    <= 1'b0;
      pend_fp   <= 1'b0;
      pend_rd   <= '0;
      left_done <= 1'b0;
    end else begin
      pend_v    <= iss_left && l_load;
      pend_fp   <= (l_cls == C_FLD);
      pend_rd   <= l_rd;
      left_done <= hold && l_go;
    end
  end

  assert_no_reissue_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (hold && iss_left) |=> !iss_left);

  assert_pair_raw_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_left && l_cls == C_FLD && r_cls == C_FOP && (r_ra == l_rd || r_rb == l_rd))
      |-> (!iss_right && hold));

  assert_fp_load_use_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_left && l_cls == C_FLD)
      |=> !(iss_right && (r_ra == $past(l_rd) || r_rb == $past(l_rd))));

  assert_right_type_R2: assert property (@(posedge clk) disable iff (!rst_n)
    iss_right |-> (r_cls == C_FOP));

  assert_left_type_R2: assert property (@(posedge clk) disable iff (!rst_n)
    iss_left |-> l_legal);

  assert_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !pkt_valid |-> (!iss_left && !iss_right && !hold));
endmodule

// File: tb/sim_dual_issue_pair.sv
module sim_dual_issue_pair;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pkt_valid = 1'b0;
  logic [63:0] pkt = '0;
  logic        iss_left, iss_right, hold;

  always #4 clk = ~clk;

  dual_issue_pair u0 (
    .clk(clk), .rst_n(rst_n), .pkt_valid(pkt_valid), .pkt(pkt),
    .iss_left(iss_left), .iss_right(iss_right), .hold(hold)
  );

  int checks = 0;
  int errors = 0;
  logic [2:0] exp_q[$];
  string      tag_q[$];
  bit         done = 1'b0;

  function automatic logic [31:0] ins(input int cls, input int rd, input int ra, input int rb);
    ins = {cls[3:0], rd[4:0], ra[4:0], rb[4:0], 13'h0a5};
  endfunction

  // driver: apply one cycle of stimulus and queue the expected outputs
  task automatic step(input logic v, input logic [31:0] l, input logic [31:0] r,
                      input logic el, input logic er, input logic eh, input string tag);
    @(negedge clk);
    pkt_valid = v;
    pkt = {r, l};
    exp_q.push_back({el, er, eh});
    tag_q.push_back(tag);
  endtask

  // monitor: compare away from the active edge
  always @(negedge clk) begin
    #2;
    if (exp_q.size() > 0) begin
      logic [2:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if ({iss_left, iss_right, hold} !== e) begin
        errors++;
        $display("FAIL %s: got L/R/H=%b%b%b expected %b%b%b", t,
                 iss_left, iss_right, hold, e[2], e[1], e[0]);
      end
    end
  end

  initial begin
    step(1'b1, ins(1,1,2,3), ins(8,4,5,6), 0,0,0, "R9 reset");
    @(negedge clk); rst_n = 1'b1;
    step(1'b0, ins(1,1,2,3), ins(8,4,5,6), 0,0,0, "R8 invalid");
    step(1'b1, ins(1,1,2,3), ins(8,4,5,6), 1,1,0, "R3 alu+fop");
    step(1'b1, ins(4,7,1,0), ins(8,8,9,10), 1,1,0, "R3 fld+fop");
    step(1'b1, ins(1,8,7,3), ins(8,11,12,13), 1,1,0, "R7 int r7 vs fp f7");
    // intra-pair RAW via source A, then retry under load latency
    step(1'b1, ins(4,3,2,0), ins(8,4,3,5), 1,0,1, "R5 pair raw A");
    step(1'b1, ins(4,3,2,0), ins(8,4,3,5), 0,0,1, "R6 retry under load");
    step(1'b1, ins(4,3,2,0), ins(8,4,3,5), 0,1,0, "R5 retry issues");
    // intra-pair RAW via source B (field position R1)
    step(1'b1, ins(4,20,2,0), ins(8,21,1,20), 1,0,1, "R1 pair raw B");
    step(1'b1, ins(4,20,2,0), ins(8,21,1,20), 0,0,1, "R6 retry B");
    step(1'b1, ins(4,20,2,0), ins(8,21,1,20), 0,1,0, "R5 retry B issues");
    // integer load-use stalls left, so nothing issues
    step(1'b1, ins(2,5,2,0), ins(8,1,2,3), 1,1,0, "R3 ild+fop");
    step(1'b1, ins(1,6,5,1), ins(8,2,3,4), 0,0,1, "R4 left stall");
    step(1'b1, ins(1,6,5,1), ins(8,2,3,4), 1,1,0, "R4 after stall");
    // wrong-type slots
    step(1'b1, ins(8,1,2,3), ins(8,4,5,6), 0,1,0, "R2 fop in left");
    step(1'b1, ins(1,1,2,3), ins(1,4,5,6), 1,0,0, "R2 alu in right");
    step(1'b1, ins(12,1,2,3), ins(9,4,5,6), 0,0,0, "R2 both illegal");
    // FP store data depends on FP load
    step(1'b1, ins(4,9,1,0), ins(0,0,0,0), 1,0,0, "R6 fld alone");
    step(1'b1, ins(5,0,1,9), ins(0,0,0,0), 0,0,1, "R6 fst data stall");
    step(1'b1, ins(5,0,1,9), ins(0,0,0,0), 1,0,0, "R6 fst issues");
    // right-only hazard against pending FP load, left passes
    step(1'b1, ins(4,12,1,0), ins(0,0,0,0), 1,0,0, "R6 fld f12");
    step(1'b1, ins(1,12,12,12), ins(8,13,12,1), 1,0,1, "R7 R6 left only");
    step(1'b1, ins(1,12,12,12), ins(8,13,12,1), 0,1,0, "R4 remainder");
    step(1'b0, ins(1,1,2,3), ins(8,4,5,6), 0,0,0, "R8 idle end");
    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 5000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule